// File: doc/BRIEF.md
# Double-Precision Compare Flag Unit

This unit compares two 64-bit IEEE-754 double-precision words and writes the result into a 64-bit condition-flag register. It sorts the pair into one of four outcomes: unordered, greater, less or equal. It then encodes that outcome on the zero, parity and carry flags and forces the overflow, sign and auxiliary-carry flags to zero. Every other bit of the flag word passes through unchanged from the current flag value that the caller supplies.

The caller presents both operands and the present flag word together with a one-cycle valid strobe. On the next clock edge the unit registers the updated flag word and raises a done pulse for one cycle. Between strobes the registered flag word holds its value. Operand fetch, signalling-NaN exceptions and any destination other than the flags are the job of the surrounding logic.

Top module: `fcmp_flag_unit`

## Requirements
- R1: If either operand is a NaN, the result is unordered and ZF (bit 6), PF (bit 2) and CF (bit 0) are all set to 1. A NaN is an operand whose exponent field, bits 62:52, is all ones and whose fraction, bits 51:0, is nonzero.
- R2: If the first operand is greater than the second, ZF, PF and CF are all 0.
- R3: If the first operand is less than the second, CF is 1 and ZF and PF are 0.
- R4: If the operands are equal, ZF is 1 and PF and CF are 0. Positive zero and negative zero are equal.
- R5: Ordering follows sign-magnitude rules. Among two negative values the one with the larger magnitude is the smaller value. Infinities are ordered values that lie beyond every finite value.
- R6: Every compare clears OF (bit 11), SF (bit 7) and AF (bit 4), whatever the outcome.
- R7: Every flag bit other than bits 0, 2, 4, 6, 7 and 11 in the output equals the same bit of the flag input sampled with the strobe.
- R8: The updated flag word appears at the first rising edge after the strobe. At that edge done rises for exactly one cycle. Without a strobe, the flag output holds its value and done stays low.
- R9: An active-low reset clears the flag output to zero and holds done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | One-cycle strobe that launches a compare |
| opA | input | 64 | First operand, raw double-precision bits |
| opB | input | 64 | Second operand, raw double-precision bits |
| flagsIn | input | 64 | Current flag register value |
| flagsOut | output | 64 | Registered, updated flag word |
| done | output | 1 | One-cycle pulse marking a fresh flagsOut |

## Verification
A wrong outcome decision, for example a reversed magnitude test for negative operands or a missing NaN check, shows up as a wrong ZF/PF/CF pattern on flagsOut in the cycle in which done is high. A bad merge mask shows up at that same edge, either as a preserved bit that has changed or as a cleared bit that is still set. A control fault in the load or done path shows up one cycle after the strobe, as a missing or stretched done pulse or as a flag word that drifts between strobes. Random operands together with directed zeros, infinities, NaNs and negative pairs reach each of these paths.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FLAG_W  = 64;
  localparam int CF_POS  = 0;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int OF_POS  = 11;

  localparam logic [FLAG_W-1:0] TOUCH_MASK =
    (FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << PF_POS) | (FLAG_W'(1) << AF_POS) |
    (FLAG_W'(1) << ZF_POS) | (FLAG_W'(1) << SF_POS) | (FLAG_W'(1) << OF_POS);

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmpOutcome_e;

  typedef struct packed {
    logic loadFlags;
    logic pulseDone;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 52
) (
  input  logic [DATA_W-1:0] word,
  output logic              isNan,
  output logic              isZero,
  output logic              signBit,
  output logic [DATA_W-2:0] magnitude
);
  localparam int EXP_W = DATA_W - 1 - FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  always_comb begin
    expField  = word[DATA_W-2 -: EXP_W];
    fracField = word[FRAC_W-1:0];
    signBit   = word[DATA_W-1];
    magnitude = word[DATA_W-2:0];
    isNan     = (&expField) && (|fracField);
    isZero    = (magnitude == '0);
  end
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  output ctrlStrobe_t strobes,
  output logic        done
);
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= startValid;
  end

  always_comb begin
    strobes.loadFlags = startValid;
    strobes.pulseDone = doneQ;
    done              = doneQ;
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int NUM_OPS = 2;

  logic [DATA_W-1:0] opWord [NUM_OPS];
  logic              nanV   [NUM_OPS];
  logic              zeroV  [NUM_OPS];
  logic              signV  [NUM_OPS];
  logic [DATA_W-2:0] magV   [NUM_OPS];

  assign opWord[0] = opA;
  assign opWord[1] = opB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gen_class
    fcmp_classify #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) class_i (
      .word     (opWord[g]),
      .isNan    (nanV[g]),
      .isZero   (zeroV[g]),
      .signBit  (signV[g]),
      .magnitude(magV[g])
    );
  end

  logic        bothZero;
  logic        aLess;
  logic        aEqual;
  cmpOutcome_e outcome;
  logic [FLAG_W-1:0] setBits;
  logic [FLAG_W-1:0] nextFlags;
  logic [FLAG_W-1:0] flagsQ;

  always_comb begin
    bothZero = zeroV[0] && zeroV[1];
    aEqual   = bothZero || (opA == opB);
    if (bothZero)                aLess = 1'b0;
    else if (signV[0] != signV[1]) aLess = signV[0];
    else if (!signV[0])          aLess = magV[0] < magV[1];
    else                         aLess = magV[1] < magV[0];

    if (nanV[0] || nanV[1]) outcome = CMP_UN;
    else if (aLess)         outcome = CMP_LT;
    else if (aEqual)        outcome = CMP_EQ;
    else                    outcome = CMP_GT;

    setBits = '0;
    unique case (outcome)
      CMP_UN: begin
        setBits[ZF_POS] = 1'b1;
        setBits[PF_POS] = 1'b1;
        setBits[CF_POS] = 1'b1;
      end
      CMP_LT: setBits[CF_POS] = 1'b1;
      CMP_EQ: setBits[ZF_POS] = 1'b1;
      default: setBits = '0;
    endcase
    nextFlags = (flagsIn & ~TOUCH_MASK) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagsQ <= '0;
    else if (strobes.loadFlags) flagsQ <= nextFlags;
  end

  assign flagsOut = flagsQ;
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FRAC_W = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              done
);
  ctrlStrobe_t strobes;

  fcmp_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .strobes   (strobes),
    .done      (done)
  );

  fcmp_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .flagsIn (flagsIn),
    .flagsOut(flagsOut)
  );
endmodule

// File: rtl/fcmp_flag_checker.sv
module fcmp_flag_checker
  import fcmp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [63:0]       opA,
  input logic [63:0]       opB,
  input logic [FLAG_W-1:0] flagsIn,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              done
);
  logic aNan, bNan;
  assign aNan = (&opA[62:52]) && (|opA[51:0]);
  assign bNan = (&opB[62:52]) && (|opB[51:0]);

  assert_reset_R9: assert property (@(posedge clk) !rstN |-> (flagsOut == '0 && !done));

  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> done);

  assert_done_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> $stable(flagsOut));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (!flagsOut[OF_POS] && !flagsOut[SF_POS] && !flagsOut[AF_POS]));

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> ((flagsOut & ~TOUCH_MASK) == ($past(flagsIn) & ~TOUCH_MASK)));

  assert_unordered_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && (aNan || bNan)) |=>
      (flagsOut[ZF_POS] && flagsOut[PF_POS] && flagsOut[CF_POS]));

  assert_ordered_nopf_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !aNan && !bNan) |=>
      (!flagsOut[PF_POS] && !(flagsOut[ZF_POS] && flagsOut[CF_POS])));
endmodule

bind fcmp_flag_unit fcmp_flag_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .opA       (opA),
  .opB       (opB),
  .flagsIn   (flagsIn),
  .flagsOut  (flagsOut),
  .done      (done)
);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [63:0] opA = '0, opB = '0, flagsIn = '0;
  logic [63:0] flagsOut;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .flagsOut(flagsOut), .done(done)
  );

  localparam logic [63:0] MASK = 64'h0000_0000_0000_08D5;
  localparam logic [63:0] P_INF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'hFFF0_0000_0000_0001;
  localparam logic [63:0] P_ONE = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_MAX = 64'h7FEF_FFFF_FFFF_FFFF;

  function automatic logic isNanBits(input logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] != 52'd0);
  endfunction

  function automatic logic [63:0] expectFlags(input logic [63:0] a, b, f);
    real ra, rb;
    logic [63:0] r;
    r = f & ~MASK;
    if (isNanBits(a) || isNanBits(b)) begin
      r[6] = 1'b1; r[2] = 1'b1; r[0] = 1'b1;
    end else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (ra < rb)       r[0] = 1'b1;
      else if (ra == rb) r[6] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runVec(input string req, input logic [63:0] a, b, f);
    logic [63:0] exp;
    logic [63:0] held;
    exp = expectFlags(a, b, f);
    @(negedge clk);
    opA = a; opB = b; flagsIn = f; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    flagsIn = ~f;
    check(req, flagsOut, exp);
    check("R8 done pulse", {63'd0, done}, 64'd1);
    held = flagsOut;
    @(negedge clk);
    check("R8 hold/done low", {flagsOut[62:0], done}, {held[62:0], 1'b0});
  endtask

  function automatic logic [63:0] pickOp(input int unsigned sel);
    logic [63:0] w;
    w = {$urandom, $urandom};
    case (sel % 8)
      0: w = P_INF;
      1: w = N_INF;
      2: w = {w[63], 11'h7FF, w[51:1], 1'b1};
      3: w = {w[63], 63'd0};
      4: w = {w[63], 11'h400, w[51:0]};
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    check("R9 reset flags", flagsOut, 64'd0);
    check("R9 reset done", {63'd0, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {flagsOut[62:0], done}, 64'd0);

    runVec("R1 qnan left", QNAN, P_ONE, 64'd0);
    runVec("R1 snan right", P_ONE, SNAN, 64'hFFFF_FFFF_FFFF_FFFF);
    runVec("R1 both nan", QNAN, QNAN, 64'h0);
    runVec("R2 greater", P_ONE, N_ONE, 64'hFFFF_FFFF_FFFF_FFFF);
    runVec("R3 less", N_ONE, P_ONE, 64'h0);
    runVec("R4 equal", P_ONE, P_ONE, 64'h1234_5678_9ABC_DEF0);
    runVec("R4 +0 vs -0", 64'd0, N_ZERO, 64'h0);
    runVec("R4 -0 vs +0", N_ZERO, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    runVec("R5 negative magnitudes", N_TWO, N_ONE, 64'h0);
    runVec("R5 negative magnitudes rev", N_ONE, N_TWO, 64'h0);
    runVec("R5 +inf vs max", P_INF, P_MAX, 64'h0);
    runVec("R5 -inf vs -max", N_INF, {1'b1, P_MAX[62:0]}, 64'h0);
    runVec("R5 inf equal", N_INF, N_INF, 64'h0);
    runVec("R6 clear OF SF AF", P_ONE, N_ONE, 64'h0000_0000_0000_0890);
    runVec("R7 preserve others", N_ONE, P_ONE, 64'hAAAA_5555_F00F_F72A);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b, f;
      a = pickOp($urandom);
      b = ($urandom % 5 == 0) ? a : pickOp($urandom);
      f = {$urandom, $urandom};
      runVec("R2/R3/R5/R7 random", a, b, f);
    end

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 reset mid-run", {flagsOut[62:0], done}, 64'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule